// File: doc/BRIEF.md
# Multi-mode LUT logic cell

This block is a behavioural model of one programmable fabric cell built around a single 64-bit storage table. A static mode input selects how that table is used. It can act as one six-input logic function, as two five-input functions fed by the same five inputs, as a 64-entry by 1-bit RAM, or as a 64-stage shift register whose output tap is picked at run time.

The six-bit `sel` bus is the function input in the two logic modes and the address in the RAM and shift modes. A configuration port replaces the whole table on one clock edge, and that load wins over any RAM write or shift in the same cycle. Switching mode never touches the stored bits, so a table written as RAM can later be read as a function or shifted.

Top module: `lut_cell`

## Requirements
- R1: While `rst_n` is low, the table clears to all zeros on each clock edge; after reset `out_main` and `out_aux` read 0 for every `sel`.
- R2: In function mode (`mode` = 0), `out_main` equals table bit `sel` and `out_aux` is 0.
- R3: In split mode (`mode` = 1), `out_main` equals table bit `sel[4:0]` and `out_aux` equals table bit 32 + `sel[4:0]`; `sel[5]` has no effect on either output.
- R4: In RAM mode (`mode` = 2), `out_main` equals table bit `sel` and follows a change of `sel` with no clock edge; `out_aux` is 0.
- R5: In RAM mode, a rising clock edge with `wr_en` high stores `din` into table bit `sel` and leaves all other bits unchanged; with `wr_en` low the table is unchanged.
- R6: In shift mode (`mode` = 3), each rising edge with `sh_en` high moves every table bit up one position, puts `din` into bit 0 and drops bit 63; `out_main` is table bit `sel`, so a bit shifted in appears at tap k after k+1 enabled edges. With `sh_en` low the table holds.
- R7: A rising edge with `cfg_load` high copies all 64 bits of `cfg_data` into the table (bit i to table bit i) in every mode, taking priority over a RAM write or a shift in the same cycle.
- R8: Changing `mode` leaves the table contents unchanged.
- R9: `wr_en` has no effect outside RAM mode and `sh_en` has no effect outside shift mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 function, 1 split, 2 RAM, 3 shift |
| sel | input | 6 | Function inputs / RAM address / shift tap |
| wr_en | input | 1 | RAM write enable |
| sh_en | input | 1 | Shift enable |
| din | input | 1 | RAM write data and shift input |
| cfg_load | input | 1 | Load the whole table from `cfg_data` |
| cfg_data | input | 64 | Table image for a load |
| out_main | output | 1 | Primary output |
| out_aux | output | 1 | Secondary output, split mode only |

## Verification
The two functions that can collide are a whole-table load and a per-cycle update, either a RAM write or a shift. The bench raises `cfg_load` in the same cycle as `wr_en` in RAM mode, and again in the same cycle as `sh_en` in shift mode. It chooses the write data and shift input so that a lost load would leave a different value at the probed taps. The result is judged by reading those taps afterwards: they must hold the loaded image and show no sign of the write or the shift.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

   typedef enum logic [1:0] {
      MODE_FUNC  = 2'd0,
      MODE_SPLIT = 2'd1,
      MODE_RAM   = 2'd2,
      MODE_SHIFT = 2'd3
   } cell_mode_e;

   typedef struct packed {
      logic wr_cmd;
      logic shift_cmd;
      logic split;
   } cell_ctl_t;

endpackage

// File: rtl/lut_cell_ctrl.sv
module lut_cell_ctrl
   import lut_cell_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       wr_en,
   input  logic       sh_en,
   output cell_ctl_t  ctl
);

   cell_mode_e mode_e;

   always_comb begin
      mode_e        = cell_mode_e'(mode);
      ctl.wr_cmd    = 1'b0;
      ctl.shift_cmd = 1'b0;
      ctl.split     = 1'b0;
      unique case (mode_e)
         MODE_FUNC:  ;
         MODE_SPLIT: ctl.split     = 1'b1;
         MODE_RAM:   ctl.wr_cmd    = wr_en;
         MODE_SHIFT: ctl.shift_cmd = sh_en;
         default:    ;
      endcase
   end

endmodule

// File: rtl/lut_cell_store.sv
module lut_cell_store #(
   parameter int ADDR_W = 6,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DEPTH-1:0]  load_data,
   input  logic              wr_cmd,
   input  logic              shift_cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic              din,
   output logic [DEPTH-1:0]  tbl
);

   logic [DEPTH-1:0] nxt;

   for (genvar i = 0; i < DEPTH; i++) begin : g_bit
      logic prev_bit;
      if (i == 0) begin : g_head
         assign prev_bit = din;
      end else begin : g_body
         assign prev_bit = tbl[i-1];
      end

      always_comb begin
         if (load) begin
            nxt[i] = load_data[i];
         end else if (wr_cmd && (addr == ADDR_W'(i))) begin
            nxt[i] = din;
         end else if (shift_cmd) begin
            nxt[i] = prev_bit;
         end else begin
            nxt[i] = tbl[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl <= '0;
      end else begin
         tbl <= nxt;
      end
   end

endmodule

// File: rtl/lut_cell_rdmux.sv
module lut_cell_rdmux #(
   parameter int ADDR_W    = 6,
   parameter bit HAS_SPLIT = 1'b1,
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic [DEPTH-1:0]  tbl,
   input  logic [ADDR_W-1:0] addr,
   input  logic              split,
   output logic              out_main,
   output logic              out_aux
);

   if (HAS_SPLIT) begin : g_split
      logic [ADDR_W-1:0] lo_idx;
      logic [ADDR_W-1:0] hi_idx;
      assign lo_idx = {1'b0, addr[ADDR_W-2:0]};
      assign hi_idx = {1'b1, addr[ADDR_W-2:0]};

      always_comb begin
         if (split) begin
            out_main = tbl[lo_idx];
            out_aux  = tbl[hi_idx];
         end else begin
            out_main = tbl[addr];
            out_aux  = 1'b0;
         end
      end
   end else begin : g_whole
      logic unused_split;
      assign unused_split = split;
      assign out_main     = tbl[addr];
      assign out_aux      = 1'b0;
   end

endmodule

// File: rtl/lut_cell.sv
module lut_cell
   import lut_cell_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter bit HAS_SPLIT = 1'b1,
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] sel,
   input  logic              wr_en,
   input  logic              sh_en,
   input  logic              din,
   input  logic              cfg_load,
   input  logic [DEPTH-1:0]  cfg_data,
   output logic              out_main,
   output logic              out_aux
);

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr_w
      $error("lut_cell: ADDR_W must lie in 2..10");
   end

   cell_ctl_t        ctl;
   logic [DEPTH-1:0] tbl_q;

   lut_cell_ctrl u_ctrl (
      .mode  (mode),
      .wr_en (wr_en),
      .sh_en (sh_en),
      .ctl   (ctl)
   );

   lut_cell_store #(.ADDR_W(ADDR_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_load),
      .load_data (cfg_data),
      .wr_cmd    (ctl.wr_cmd),
      .shift_cmd (ctl.shift_cmd),
      .addr      (sel),
      .din       (din),
      .tbl       (tbl_q)
   );

   lut_cell_rdmux #(.ADDR_W(ADDR_W), .HAS_SPLIT(HAS_SPLIT)) u_rdmux (
      .tbl      (tbl_q),
      .addr     (sel),
      .split    (ctl.split),
      .out_main (out_main),
      .out_aux  (out_aux)
   );

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
   parameter int ADDR_W = 6,
   localparam int DEPTH = 1 << ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic [ADDR_W-1:0] sel,
   input logic              wr_en,
   input logic              sh_en,
   input logic              din,
   input logic              cfg_load,
   input logic [DEPTH-1:0]  cfg_data,
   input logic [DEPTH-1:0]  tbl_q,
   input logic              out_aux
);

   p_load_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> tbl_q == $past(cfg_data));

   p_ram_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && wr_en && !cfg_load) |=> tbl_q[$past(sel)] == $past(din));

   p_shift_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && sh_en && !cfg_load) |=>
         tbl_q == {$past(tbl_q[DEPTH-2:0]), $past(din)});

   p_logic_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] == 1'b0 && !cfg_load) |=> $stable(tbl_q));

   p_aux_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd1) |-> out_aux == 1'b0);

endmodule

bind lut_cell lut_cell_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .sel      (sel),
   .wr_en    (wr_en),
   .sh_en    (sh_en),
   .din      (din),
   .cfg_load (cfg_load),
   .cfg_data (cfg_data),
   .tbl_q    (tbl_q),
   .out_aux  (out_aux)
);

// File: tb/sim_lut_cell.sv
module sim_lut_cell;

   localparam logic [63:0] PAT = 64'hF0F0_FF00_FFFF_00FF;

   // {mode[1:0], sel[5:0], exp_main, exp_aux}
   localparam int NVEC = 15;
   localparam logic [9:0] VEC [NVEC] = '{
      {2'd0, 6'd0,  1'b1, 1'b0},
      {2'd0, 6'd9,  1'b0, 1'b0},
      {2'd0, 6'd20, 1'b1, 1'b0},
      {2'd0, 6'd33, 1'b0, 1'b0},
      {2'd0, 6'd44, 1'b1, 1'b0},
      {2'd0, 6'd58, 1'b0, 1'b0},
      {2'd0, 6'd63, 1'b1, 1'b0},
      {2'd1, 6'd3,  1'b1, 1'b0},
      {2'd1, 6'd8,  1'b0, 1'b1},
      {2'd1, 6'd12, 1'b0, 1'b1},
      {2'd1, 6'd28, 1'b1, 1'b1},
      {2'd1, 6'd60, 1'b1, 1'b1},
      {2'd2, 6'd9,  1'b0, 1'b0},
      {2'd2, 6'd44, 1'b1, 1'b0},
      {2'd3, 6'd58, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode;
   logic [5:0]  sel;
   logic        wr_en, sh_en, din, cfg_load;
   logic [63:0] cfg_data;
   logic        out_main, out_aux;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   lut_cell u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .sel      (sel),
      .wr_en    (wr_en),
      .sh_en    (sh_en),
      .din      (din),
      .cfg_load (cfg_load),
      .cfg_data (cfg_data),
      .out_main (out_main),
      .out_aux  (out_aux)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b (mode=%0d sel=%0d)", req, act, exp, mode, sel);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic probe(input logic [5:0] s, input string req, input logic exp);
      sel = s;
      #1;
      chk(req, out_main, exp);
   endtask

   initial begin
      rst_n = 1'b0; mode = 2'd0; sel = '0; wr_en = 1'b0; sh_en = 1'b0;
      din = 1'b0; cfg_load = 1'b0; cfg_data = '0;
      repeat (3) step();
      probe(6'd0, "R1", 1'b0);
      probe(6'd63, "R1", 1'b0);
      mode = 2'd1; sel = 6'd63; #1;
      chk("R1", out_aux, 1'b0);
      rst_n = 1'b1;

      // R7: load collides with a RAM write of 0 to bit 0
      mode = 2'd2; sel = 6'd0; din = 1'b0; wr_en = 1'b1; sh_en = 1'b1;
      cfg_load = 1'b1; cfg_data = PAT;
      step();
      cfg_load = 1'b0; wr_en = 1'b0; sh_en = 1'b0;
      probe(6'd0, "R7", 1'b1);
      probe(6'd8, "R7", 1'b0);

      // R2 R3 R4 R6: table-driven reads of the loaded image
      for (int k = 0; k < NVEC; k++) begin
         mode = VEC[k][9:8];
         sel  = VEC[k][7:2];
         #1;
         chk("R2/R3 main", out_main, VEC[k][1]);
         chk("R2/R3 aux",  out_aux,  VEC[k][0]);
      end

      // R4: RAM read follows sel with no edge
      mode = 2'd2;
      probe(6'd9,  "R4", 1'b0);
      probe(6'd44, "R4", 1'b1);

      // R5: clocked write
      sel = 6'd9; din = 1'b1; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
      probe(6'd9,  "R5", 1'b1);
      probe(6'd10, "R5", 1'b0);
      sel = 6'd9; din = 1'b0;
      step();
      probe(6'd9, "R5", 1'b1);

      // R8: RAM contents visible in function mode
      mode = 2'd0;
      probe(6'd9, "R8", 1'b1);

      // R9: enables ignored in function and split modes, sh_en in RAM mode
      sel = 6'd0; din = 1'b0; wr_en = 1'b1; sh_en = 1'b1;
      step();
      wr_en = 1'b0; sh_en = 1'b0;
      probe(6'd0,  "R9", 1'b1);
      probe(6'd10, "R9", 1'b0);
      mode = 2'd1; sel = 6'd0; wr_en = 1'b1; sh_en = 1'b1;
      step();
      wr_en = 1'b0; sh_en = 1'b0; mode = 2'd0;
      probe(6'd0,  "R9", 1'b1);
      probe(6'd10, "R9", 1'b0);
      mode = 2'd2; sh_en = 1'b1;
      step();
      sh_en = 1'b0;
      probe(6'd10, "R9", 1'b0);

      // R6: shift register
      cfg_load = 1'b1; cfg_data = '0;
      step();
      cfg_load = 1'b0;
      mode = 2'd3; din = 1'b1; sh_en = 1'b1;
      step();
      din = 1'b0;
      probe(6'd0, "R6", 1'b1);
      repeat (4) step();
      probe(6'd4, "R6", 1'b1);
      probe(6'd3, "R6", 1'b0);
      probe(6'd5, "R6", 1'b0);
      sh_en = 1'b0;
      step();
      probe(6'd4, "R6", 1'b1);
      sel = 6'd0; din = 1'b1; wr_en = 1'b1;
      step();
      wr_en = 1'b0; din = 1'b0;
      probe(6'd0, "R9", 1'b0);
      probe(6'd4, "R9", 1'b1);
      sh_en = 1'b1;
      repeat (59) step();
      probe(6'd63, "R6", 1'b1);
      probe(6'd62, "R6", 1'b0);
      step();
      probe(6'd63, "R6", 1'b0);

      // R7: load collides with a shift
      cfg_load = 1'b1; cfg_data = PAT; din = 1'b0; sh_en = 1'b1;
      step();
      cfg_load = 1'b0; sh_en = 1'b0;
      probe(6'd0, "R7", 1'b1);
      probe(6'd8, "R7", 1'b0);

      // R8: shift contents kept in RAM mode
      mode = 2'd2;
      probe(6'd44, "R8", 1'b1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule